// File: doc/BRIEF.md
# Interrupt Request Flag Controller

This block holds one latched request flag per interrupt source and one enable bit per source. It drives a single interrupt line to the processor. Eight bit positions are defined. Seven of them carry a source: a timer event, a serial-channel event and five external request lines. The remaining position is unused and reads back as a constant one in the flag view.

Each source delivers a one-cycle pulse, and that pulse sets its flag. A flag stays set until software writes 0 to that bit. Writing 1 to a flag does nothing, and the processor's acknowledge input never clears a flag.

Software reaches both registers through a small synchronous register port with an address, a write strobe, write data and combinational read data. The interrupt line is high whenever any implemented flag is set while its enable bit is also set.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag view (address 1) reads 0x20, the enable view (address 0) reads 0x00 and `irq_o` is low.
- R2: Flag bit positions: bit 7 is the timer request, bit 6 is the serial request, and bits 4..0 are external lines 4..0. A pulse on `src_i[5]` has no effect.
- R3: A pulse on `src_i[k]` sets flag k at the next clock edge, and the flag stays set with no further pulses.
- R4: A write to address 1 clears each flag whose write-data bit is 0. Flags whose write-data bit is 1 keep their value.
- R5: If a source pulse and a clearing write hit the same flag in the same cycle, the flag ends at 1.
- R6: `ack_i` leaves all flags and enables unchanged.
- R7: The enable register resets to 0. A write to address 0 stores write-data bits 7, 6 and 4..0 at the next edge, and bit 5 always reads 0.
- R8: `irq_o` equals the OR over bits 7, 6 and 4..0 of (flag AND enable), formed combinationally from the stored registers.
- R9: Reads at any address other than 0 or 1 return 0x00. Writes to those addresses change nothing.
- R10: Flag bit 5 reads 1 at all times and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Register address (0 enable, 1 flags) |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| src_i | input | 8 | One-cycle request pulses, one per bit position |
| ack_i | input | 1 | Processor acknowledge, no effect on state |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach is a source pulse landing in exactly the cycle that software writes 0 to the same flag. The stimulus builds it on purpose: it raises a flag, then issues the clearing write with the same bit pulsing. Randomised cycles then mix pulses, partial-clear masks, enable writes and acknowledges, so that collisions on several bits happen together. A behavioural model in the bench compares the read data and the interrupt line on every cycle.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [7:0]        src_i,
  input  logic              ack_i,
  output logic              irq_o
);
  localparam logic [7:0] IMPL   = 8'hDF;
  localparam logic [7:0] FIXED1 = 8'h20;

  logic [7:0] flag_q, en_q, clr;
  logic       wr_en, wr_fl;

  assign wr_en = we_i && (addr_i == ADDR_W'(0));
  assign wr_fl = we_i && (addr_i == ADDR_W'(1));
  assign clr   = wr_fl ? ~wdata_i : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 8'h00;
      en_q   <= 8'h00;
    end else begin
      flag_q <= ((flag_q & ~clr) | src_i) & IMPL;
      if (wr_en) en_q <= wdata_i & IMPL;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(0): rdata_o = en_q;
      ADDR_W'(1): rdata_o = flag_q | FIXED1;
      default:    rdata_o = 8'h00;
    endcase
  end

  assign irq_o = |(flag_q & en_q & IMPL);

  a_r3_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i != 8'h00) |=> ((flag_q & $past(src_i & IMPL)) == $past(src_i & IMPL)));

  a_r4_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fl |=> ((flag_q & $past(wdata_i & ~src_i & IMPL)) ==
               ($past(flag_q) & $past(wdata_i & ~src_i & IMPL))));

  a_r6_ack_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !we_i && src_i == 8'h00) |=> ($stable(flag_q) && $stable(en_q)));

  a_r7_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == ($past(wdata_i) & IMPL)));

  a_r10_bit5_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == ADDR_W'(1)) |-> rdata_o[5]);

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q != 8'h00 && flag_q != 8'h00));
endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] src_i = 8'h00;
  logic       ack_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int fails = 0;
  int m_flags = 0;
  int m_en = 0;

  always #10 clk = ~clk;

  irq_flag_ctrl #(.ADDR_W(2)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .src_i(src_i), .ack_i(ack_i), .irq_o(irq_o));

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flags = 0;
      m_en = 0;
    end else begin
      for (int b = 0; b < 8; b++) begin
        if (b == 5) continue;
        if (src_i[b]) m_flags[b] = 1;
        else if (we_i && addr_i == 2'd1 && !wdata_i[b]) m_flags[b] = 0;
        if (we_i && addr_i == 2'd0) m_en[b] = wdata_i[b];
      end
    end
  end

  function automatic int exp_rd(input int a);
    if (a == 0) return m_en & 8'hFF;
    if (a == 1) return (m_flags | 32'h20) & 8'hFF;
    return 0;
  endfunction

  function automatic bit exp_irq();
    for (int b = 0; b < 8; b++)
      if (b != 5 && m_flags[b] && m_en[b]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req);
    checks++;
    if (int'(rdata_o) != exp_rd(int'(addr_i))) begin
      fails++;
      $display("FAIL %s: rdata addr %0d actual %h expected %h", req, addr_i, rdata_o, exp_rd(int'(addr_i)));
    end
    checks++;
    if (irq_o != exp_irq()) begin
      fails++;
      $display("FAIL %s: irq actual %0b expected %0b", req, irq_o, exp_irq());
    end
  endtask

  task automatic step(input string req, input logic [1:0] a, input logic w,
                      input logic [7:0] d, input logic [7:0] s, input logic k);
    @(negedge clk);
    addr_i = a; we_i = w; wdata_i = d; src_i = s; ack_i = k;
    #1 check(req);
  endtask

  task automatic rd(input string req, input logic [1:0] a);
    step(req, a, 1'b0, 8'h00, 8'h00, 1'b0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd("R1", 2'd1);
    rd("R1", 2'd0);
    rst_n = 1'b1;
    rd("R1", 2'd1);
    rd("R9", 2'd2);
    rd("R9", 2'd3);
    // R2 R3: each position in turn, including unused bit 5
    for (int b = 0; b < 8; b++) begin
      step("R2", 2'd1, 1'b0, 8'h00, 8'h01 << b, 1'b0);
      rd("R3", 2'd1);
      rd("R3", 2'd1);
    end
    // R4: write ones keeps, write zeros clears selected bits
    step("R4", 2'd1, 1'b1, 8'hFF, 8'h00, 1'b0);
    rd("R4", 2'd1);
    step("R4", 2'd1, 1'b1, 8'h3C, 8'h00, 1'b0);
    rd("R4", 2'd1);
    // R10: try to clear bit 5
    step("R10", 2'd1, 1'b1, 8'h00, 8'h00, 1'b0);
    rd("R10", 2'd1);
    // R5: set and clear collide on bit 7 and bit 0
    step("R5", 2'd1, 1'b0, 8'h00, 8'h81, 1'b0);
    step("R5", 2'd1, 1'b1, 8'h00, 8'h81, 1'b0);
    rd("R5", 2'd1);
    // R7: enable register
    step("R7", 2'd0, 1'b1, 8'hFF, 8'h00, 1'b0);
    rd("R7", 2'd0);
    rd("R8", 2'd0);
    step("R8", 2'd0, 1'b1, 8'h02, 8'h00, 1'b0);
    rd("R8", 2'd0);
    step("R8", 2'd1, 1'b0, 8'h00, 8'h02, 1'b0);
    rd("R8", 2'd1);
    // R6: acknowledge while flags set
    step("R6", 2'd1, 1'b0, 8'h00, 8'h00, 1'b1);
    step("R6", 2'd1, 1'b0, 8'h00, 8'h00, 1'b1);
    rd("R6", 2'd1);
    rd("R6", 2'd0);
    // R9: writes to unmapped addresses
    step("R9", 2'd2, 1'b1, 8'h00, 8'h00, 1'b0);
    step("R9", 2'd3, 1'b1, 8'h00, 8'h00, 1'b0);
    rd("R9", 2'd1);
    rd("R9", 2'd0);
    // R8: random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] s;
      s = 8'($urandom) & 8'($urandom);
      step("R8", 2'($urandom), 1'($urandom), 8'($urandom), s, 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule